// File: doc/BRIEF.md
# Masked PCI Configuration Register File

This block holds the 256-byte configuration space of one PCI function. The function can be an endpoint (type-0 header) or a bridge (type-1 header). Writability is set bit by bit through a byte-wide mask table. The table is fixed by parameters at elaboration, so no address list is decoded at write time. Each written byte keeps its read-only bits and takes the new value only where its mask bit is set.

The BAR and expansion-ROM masks come from the region sizes given as parameters. A write that actually changes a BAR byte, or flips the command register's I/O or memory enable, raises a one-cycle `remap` pulse. Whatever address decoding sits downstream uses that pulse to reload its windows. In bridge mode the stored secondary bus number is driven out continuously.

Top module: `cfg_space_regfile`

## Requirements
- R1: After reset, bytes 0x00–0x03 hold `ID_WORD` little-endian. Byte 0x0E holds 0x01 in bridge mode and 0x00 otherwise. The lowest byte of each present BAR holds its 4-bit type value. Every other byte is 0x00, and `remap` is low.
- R2: A byte write stores (old & ~mask) | (new & mask). Bits whose mask is 0 keep their value.
- R3: In the header (0x00–0x3F), bytes 0x0C and 0x3C have mask 0xFF and byte 0x04 has mask 0x07. All other header bytes are read-only, except those covered by R5, R6 and R9.
- R4: Bytes 0x40 to 0xFF have mask 0xFF.
- R5: BAR n occupies 0x10+4n. There are six BARs, or two in bridge mode. Its 32-bit mask is ~(size−1), or all zero when the size is 0. This keeps the type bits and the bits below the size.
- R6: The expansion-ROM BAR occupies 0x30, or 0x38 in bridge mode. Its mask is ~(size−1)|1, or zero when the size is 0.
- R7: A write of length 2 or 4 stores consecutive bytes from `wr_addr`, with the least significant byte at the lowest address. Bytes that would land at or beyond 0x100 are dropped.
- R8: `remap` is high in the cycle after a write that changed any byte in 0x10–0x27, or toggled command bit 0 or bit 1. It stays low after writes that change nothing there, including bus-master-only changes and identical rewrites.
- R9: In bridge mode, bytes 0x18–0x1A have mask 0xFF and `sec_bus` always equals stored byte 0x19. In endpoint mode `sec_bus` is 0.
- R10: A write with `wr_len` other than 1, 2 or 4 changes no byte.
- R11: `rd_data` presents, one cycle after `rd_addr`, the four bytes starting at `rd_addr`, little-endian. Bytes beyond 0xFF read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 8 | Byte address of the first written byte |
| wr_len | input | 3 | Write length in bytes: 1, 2 or 4 |
| wr_data | input | 32 | Write data, lowest byte goes to `wr_addr` |
| rd_addr | input | 8 | Byte address of the read window |
| rd_data | output | 32 | Registered four-byte read window |
| remap | output | 1 | One-cycle pulse after a BAR or enable change |
| sec_bus | output | 8 | Secondary bus number (bridge mode) |

## Verification
The hardest case is telling a write that really changed a BAR or enable bit apart from one that only touched it. Examples of the latter are identical rewrites, bus-master-only changes, and writes whose bits all fall under a zero mask. The bench walks every byte address with all-ones and then all-zeros data on an endpoint and a bridge instance side by side. After each write it predicts `remap` from its own before/after image. It then issues targeted rewrites of unchanged values and a four-byte write straddling the end of the space.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;
  typedef logic [7:0] cfg_byte_t;

  localparam int OFS_CMD      = 'h04;
  localparam int OFS_HDR_TYPE = 'h0E;
  localparam int OFS_CLS      = 'h0C;
  localparam int OFS_BAR_LO   = 'h10;
  localparam int OFS_BAR_HI   = 'h27;
  localparam int OFS_PRI_BUS  = 'h18;
  localparam int OFS_SUB_BUS  = 'h1A;
  localparam int OFS_SEC_BUS  = 'h19;
  localparam int OFS_ROM_EP   = 'h30;
  localparam int OFS_ROM_BR   = 'h38;
  localparam int OFS_INT_LINE = 'h3C;
  localparam int HDR_END      = 'h40;
  localparam logic [7:0] CMD_ENABLE_BITS = 8'h03;
endpackage

// File: rtl/cfgsp_mask_gen.sv
module cfgsp_mask_gen
  import cfgsp_pkg::*;
#(
  parameter int                CFG_BYTES = 256,
  parameter bit                BRIDGE    = 1'b0,
  parameter logic [31:0]       ID_WORD   = 32'h0000_0000,
  parameter logic [5:0][31:0]  BAR_SIZE  = '0,
  parameter logic [5:0][3:0]   BAR_TYPE  = '0,
  parameter logic [31:0]       ROM_SIZE  = 32'h0
) (
  output cfg_byte_t [CFG_BYTES-1:0] mask_tbl,
  output cfg_byte_t [CFG_BYTES-1:0] rst_tbl
);
  localparam int NBARS   = BRIDGE ? 2 : 6;
  localparam int ROM_OFS = BRIDGE ? OFS_ROM_BR : OFS_ROM_EP;

  function automatic cfg_byte_t mask_at(int a);
    logic [31:0] w;
    int n;
    if (a >= HDR_END) return 8'hFF;
    if (a == OFS_CLS || a == OFS_INT_LINE) return 8'hFF;
    if (a == OFS_CMD) return 8'h07;
    if (BRIDGE && a >= OFS_PRI_BUS && a <= OFS_SUB_BUS) return 8'hFF;
    if (a >= OFS_BAR_LO && a < OFS_BAR_LO + 4*NBARS) begin
      n = (a - OFS_BAR_LO) / 4;
      w = (BAR_SIZE[n] == 32'h0) ? 32'h0 : ~(BAR_SIZE[n] - 32'd1);
      return w[8*(a%4) +: 8];
    end
    if (a >= ROM_OFS && a < ROM_OFS + 4) begin
      w = (ROM_SIZE == 32'h0) ? 32'h0 : (~(ROM_SIZE - 32'd1) | 32'h1);
      return w[8*(a%4) +: 8];
    end
    return 8'h00;
  endfunction

  function automatic cfg_byte_t rst_at(int a);
    if (a < 4) return ID_WORD[8*a +: 8];
    if (a == OFS_HDR_TYPE) return BRIDGE ? 8'h01 : 8'h00;
    if (a >= OFS_BAR_LO && a < OFS_BAR_LO + 4*NBARS && (a % 4) == 0)
      return {4'h0, BAR_TYPE[(a - OFS_BAR_LO) / 4]};
    return 8'h00;
  endfunction

  for (genvar i = 0; i < CFG_BYTES; i++) begin : g_tbl
    assign mask_tbl[i] = mask_at(i);
    assign rst_tbl[i]  = rst_at(i);
  end
endmodule

// File: rtl/cfgsp_write_lane.sv
module cfgsp_write_lane
  import cfgsp_pkg::*;
#(
  parameter int LANE      = 0,
  parameter int CFG_BYTES = 256,
  parameter int ADDR_W    = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] base,
  input  logic [2:0]        len,
  input  cfg_byte_t         din,
  input  cfg_byte_t         old_byte,
  input  cfg_byte_t         mask,
  output logic [ADDR_W-1:0] addr,
  output logic              we,
  output cfg_byte_t         new_byte,
  output logic              bar_chg,
  output logic              cmd_chg
);
  logic [ADDR_W:0] sum;
  logic            len_ok;
  logic            in_range;

  always_comb begin
    sum      = {1'b0, base} + (ADDR_W+1)'(LANE);
    in_range = (int'(sum) < CFG_BYTES);
    len_ok   = (len == 3'd1) || (len == 3'd2) || (len == 3'd4);
    addr     = sum[ADDR_W-1:0];
    we       = wr_en && len_ok && (3'(LANE) < len) && in_range;
    new_byte = (old_byte & ~mask) | (din & mask);
    bar_chg  = we && (int'(addr) >= OFS_BAR_LO) && (int'(addr) <= OFS_BAR_HI)
               && (new_byte != old_byte);
    cmd_chg  = we && (int'(addr) == OFS_CMD)
               && (((new_byte ^ old_byte) & CMD_ENABLE_BITS) != 8'h00);
  end
endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
  import cfgsp_pkg::*;
#(
  parameter int                CFG_BYTES = 256,
  parameter int                LANES     = 4,
  parameter bit                BRIDGE    = 1'b0,
  parameter logic [31:0]       ID_WORD   = 32'h1234_ABCD,
  parameter logic [5:0][31:0]  BAR_SIZE  = {32'h10, 32'h0, 32'h1000, 32'h0, 32'h20, 32'h100},
  parameter logic [5:0][3:0]   BAR_TYPE  = {4'h1, 4'h0, 4'h8, 4'h0, 4'h1, 4'h0},
  parameter logic [31:0]       ROM_SIZE  = 32'h800
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [2:0]  wr_len,
  input  logic [31:0] wr_data,
  input  logic [7:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        remap,
  output logic [7:0]  sec_bus
);
  localparam int ADDR_W = $clog2(CFG_BYTES);

  cfg_byte_t [CFG_BYTES-1:0] mask_tbl;
  cfg_byte_t [CFG_BYTES-1:0] rst_tbl;
  cfg_byte_t [CFG_BYTES-1:0] mem_q;

  logic [LANES-1:0][ADDR_W-1:0] ln_addr;
  logic [LANES-1:0]             ln_we;
  cfg_byte_t [LANES-1:0]        ln_new;
  logic [LANES-1:0]             ln_bar;
  logic [LANES-1:0]             ln_cmd;

  cfgsp_mask_gen #(
    .CFG_BYTES(CFG_BYTES), .BRIDGE(BRIDGE), .ID_WORD(ID_WORD),
    .BAR_SIZE(BAR_SIZE), .BAR_TYPE(BAR_TYPE), .ROM_SIZE(ROM_SIZE)
  ) u_masks (
    .mask_tbl(mask_tbl),
    .rst_tbl (rst_tbl)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    cfgsp_write_lane #(.LANE(k), .CFG_BYTES(CFG_BYTES), .ADDR_W(ADDR_W)) u_lane (
      .wr_en   (wr_en),
      .base    (wr_addr[ADDR_W-1:0]),
      .len     (wr_len),
      .din     (wr_data[8*k +: 8]),
      .old_byte(mem_q[ln_addr[k]]),
      .mask    (mask_tbl[ln_addr[k]]),
      .addr    (ln_addr[k]),
      .we      (ln_we[k]),
      .new_byte(ln_new[k]),
      .bar_chg (ln_bar[k]),
      .cmd_chg (ln_cmd[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q <= rst_tbl;
      remap <= 1'b0;
    end else begin
      for (int k = 0; k < LANES; k++)
        if (ln_we[k]) mem_q[ln_addr[k]] <= ln_new[k];
      remap <= (|ln_bar) || (|ln_cmd);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      for (int k = 0; k < LANES; k++) begin
        logic [ADDR_W:0] ra;
        ra = {1'b0, rd_addr[ADDR_W-1:0]} + (ADDR_W+1)'(k);
        rd_data[8*k +: 8] <= (int'(ra) < CFG_BYTES) ? mem_q[ra[ADDR_W-1:0]] : 8'h00;
      end
    end
  end

  assign sec_bus = BRIDGE ? mem_q[OFS_SEC_BUS] : 8'h00;

  logic len_valid;
  assign len_valid = (wr_len == 3'd1) || (wr_len == 3'd2) || (wr_len == 3'd4);

  AST_RO_BITS_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((mem_q[$past(wr_addr)] ^ $past(mem_q[wr_addr]))
               & ~mask_tbl[$past(wr_addr)]) == 8'h00); // R2

  AST_HDR_TYPE_FIXED: assert property (@(posedge clk) disable iff (rst)
    $stable(mem_q[OFS_HDR_TYPE])); // R3

  AST_REMAP_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    remap |-> $past(wr_en)); // R8

  AST_BAD_LEN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !len_valid) |=> $stable(mem_q)); // R10

  AST_BAD_LEN_NO_REMAP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !len_valid) |=> !remap); // R8
endmodule

// File: tb/sim_cfg_space_regfile.sv
`timescale 1ns/1ps
module sim_cfg_space_regfile;
  localparam logic [31:0]      P_ID   = 32'h1234_ABCD;
  localparam logic [5:0][31:0] P_SIZE = {32'h10, 32'h0, 32'h1000, 32'h0, 32'h20, 32'h100};
  localparam logic [5:0][3:0]  P_TYPE = {4'h1, 4'h0, 4'h8, 4'h0, 4'h1, 4'h0};
  localparam logic [31:0]      P_ROM  = 32'h800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [2:0] wr_len = '0;
  logic [31:0] wr_data = '0;
  logic [7:0] rd_addr = '0;
  logic [31:0] rd_data [2];
  logic remap [2];
  logic [7:0] sec_bus [2];

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] mdl [2][256];
  logic exp_remap [2];

  always #2 clk = ~clk;

  cfg_space_regfile #(.BRIDGE(1'b0), .ID_WORD(P_ID), .BAR_SIZE(P_SIZE),
                      .BAR_TYPE(P_TYPE), .ROM_SIZE(P_ROM)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_len(wr_len),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data[0]),
    .remap(remap[0]), .sec_bus(sec_bus[0]));

  cfg_space_regfile #(.BRIDGE(1'b1), .ID_WORD(P_ID), .BAR_SIZE(P_SIZE),
                      .BAR_TYPE(P_TYPE), .ROM_SIZE(P_ROM)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_len(wr_len),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data[1]),
    .remap(remap[1]), .sec_bus(sec_bus[1]));

  function automatic logic [7:0] exp_mask(int br, int a);
    int nb = br ? 2 : 6;
    int ro = br ? 'h38 : 'h30;
    logic [31:0] w;
    if (a >= 'h40) return 8'hFF;
    if (a == 'h0C || a == 'h3C) return 8'hFF;
    if (a == 'h04) return 8'h07;
    if (br != 0 && a >= 'h18 && a <= 'h1A) return 8'hFF;
    if (a >= 'h10 && a < 'h10 + 4*nb) begin
      w = P_SIZE[(a-'h10)/4];
      w = (w == 0) ? 32'h0 : (32'hFFFF_FFFF - (w - 1));
      return 8'(w >> (8*(a%4)));
    end
    if (a >= ro && a < ro + 4) begin
      w = (P_ROM == 0) ? 32'h0 : ((32'hFFFF_FFFF - (P_ROM - 1)) | 32'h1);
      return 8'(w >> (8*(a%4)));
    end
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_rst(int br, int a);
    int nb = br ? 2 : 6;
    if (a < 4) return 8'(P_ID >> (8*a));
    if (a == 'h0E) return br ? 8'h01 : 8'h00;
    if (a >= 'h10 && a < 'h10 + 4*nb && (a%4) == 0) return {4'h0, P_TYPE[(a-'h10)/4]};
    return 8'h00;
  endfunction

  function automatic string tag_of(int br, int a);
    int nb = br ? 2 : 6;
    int ro = br ? 'h38 : 'h30;
    if (a >= 'h40) return "R4";
    if (br != 0 && a >= 'h18 && a <= 'h1A) return "R9";
    if (a >= 'h10 && a < 'h10 + 4*nb) return "R5";
    if (a >= ro && a < ro + 4) return "R6";
    return "R3";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_write(int a, int len, logic [31:0] d);
    for (int b = 0; b < 2; b++) begin
      exp_remap[b] = 1'b0;
      if (len == 1 || len == 2 || len == 4) begin
        for (int k = 0; k < len; k++) begin
          int ad = a + k;
          if (ad < 256) begin
            logic [7:0] m = exp_mask(b, ad);
            logic [7:0] o = mdl[b][ad];
            logic [7:0] n = (o & ~m) | (8'(d >> (8*k)) & m);
            if (ad >= 'h10 && ad <= 'h27 && n != o) exp_remap[b] = 1'b1;
            if (ad == 'h04 && ((n ^ o) & 8'h03) != 0) exp_remap[b] = 1'b1;
            mdl[b][ad] = n;
          end
        end
      end
    end
  endtask

  task automatic wr(int a, int len, logic [31:0] d);
    model_write(a, len, d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_len = 3'(len); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    for (int b = 0; b < 2; b++)
      chk("R8", {31'b0, remap[b]}, {31'b0, exp_remap[b]}, $sformatf("remap inst%0d addr %h", b, a));
    chk("R9", {24'b0, sec_bus[1]}, {24'b0, mdl[1]['h19]}, "bridge sec_bus");
    chk("R9", {24'b0, sec_bus[0]}, 32'h0, "endpoint sec_bus");
  endtask

  task automatic rd_chk(int a, string req0, string req1);
    logic [31:0] e;
    @(negedge clk);
    rd_addr = 8'(a);
    @(negedge clk);
    for (int b = 0; b < 2; b++) begin
      e = '0;
      for (int k = 0; k < 4; k++)
        if (a + k < 256) e[8*k +: 8] = mdl[b][a+k];
      chk(b ? req1 : req0, rd_data[b], e, $sformatf("read inst%0d addr %h", b, a));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 256; a++) mdl[b][a] = exp_rst(b, a);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset image and idle remap
    for (int b = 0; b < 2; b++) chk("R1", {31'b0, remap[b]}, 32'h0, "remap after reset");
    for (int a = 0; a < 256; a += 4) rd_chk(a, "R1", "R1");

    // R2..R6, R9: per-byte sweep with all-ones then all-zeros data
    for (int a = 0; a < 256; a++) begin
      wr(a, 1, 32'hFF);
      rd_chk(a, tag_of(0, a), tag_of(1, a));
      wr(a, 1, 32'h00);
      rd_chk(a, tag_of(0, a), tag_of(1, a));
    end

    // R2/R5: partial merge into BAR0 keeps type and sub-size bits
    wr('h10, 4, 32'hDEAD_BEEF);
    rd_chk('h10, "R5", "R5");
    wr('h10, 4, 32'hDEAD_BEEF);          // R8: identical rewrite, no pulse
    wr('h14, 1, 32'hA5);
    rd_chk('h14, "R2", "R2");

    // R8: bus master only, then memory enable
    wr('h04, 1, 32'h04);
    wr('h04, 1, 32'h06);
    wr('h04, 2, 32'hFF06);
    wr('h50, 1, 32'h77);

    // R6: ROM enable bit
    wr('h30, 4, 32'hFFFF_FFFF);
    rd_chk('h30, "R6", "R6");
    wr('h38, 4, 32'h0000_0801);
    rd_chk('h38, "R6", "R6");

    // R7/R11: end of space
    wr('hFD, 4, 32'h1122_3344);
    rd_chk('hFC, "R7", "R7");
    rd_chk('hFE, "R11", "R11");
    rd_chk('hFF, "R11", "R11");
    wr('hFF, 2, 32'h0000_5566);
    rd_chk('hFC, "R7", "R7");
    wr('h41, 2, 32'hBEEF);
    rd_chk('h40, "R7", "R7");

    // R9: secondary bus through a 16-bit write at 0x18
    wr('h18, 2, 32'h0000_3412);
    rd_chk('h18, "R9", "R9");

    // R10: illegal lengths
    wr('h40, 3, 32'hCAFE_F00D);
    rd_chk('h40, "R10", "R10");
    wr('h60, 0, 32'hCAFE_F00D);
    rd_chk('h60, "R10", "R10");
    wr('h10, 7, 32'h0000_0000);
    rd_chk('h10, "R10", "R10");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule